// File: doc/BRIEF.md
# Trace Event Qualifier with Start/Stop Window

This block sits beside a memory-bus monitor port and decides, one command at a time, whether the command is recorded in a trace. Each command carries a 6-bit opcode, a 5-bit source ID, a 5-bit destination ID and an address. Three match units judge the command: a filter, a start trigger and a stop trigger. Each unit holds a 64-bit per-opcode enable mask, a 32-bit source mask, a 32-bit destination mask, and an address compare value with an address mask. A unit hits when the opcode's bit, the source's bit and the destination's bit are all set in their masks, and the address agrees with the compare value on every bit where the address mask is 1.

With triggers off, the filter alone decides. With triggers on, recording happens only inside a window. A start hit opens the window, beginning with the start command itself. A stop hit closes the window once the stop command has been recorded. Inside the window, a command that hits the filter, the start trigger or the stop trigger is recorded. The decision appears as a one-cycle `rec_strobe` in the cycle after the command is presented. `window_active` shows the window state. Two opcodes, idle and I/O response, are never recorded and never fire a trigger.

The window is a four-state machine. The states are OFF (tracing disabled), FREE (tracing with triggers off), ARMED (triggers on, window closed) and OPEN (triggers on, window open).

- From OFF: raising `trace_en` moves to FREE when triggers are off. With triggers on it moves to ARMED, or straight to OPEN if the same command is a start-only hit.
- From ARMED: a start hit without a stop hit gives OPEN.
- From OPEN: a stop hit gives ARMED.
- From ARMED or OPEN: dropping `trig_en` gives FREE.
- From FREE: raising `trig_en` gives ARMED.
- From any state: dropping `trace_en` gives OFF.

Top module: `trace_qual_top`

## Requirements
- R1: After reset, `rec_strobe` and `window_active` are both 0.
- R2: Commands with opcode 0 (idle) or opcode 7 (I/O response) are never recorded, even when every mask bit is set, and they fire no trigger.
- R3: A match unit hits only when all four tests pass: bit `cmd_op` of the opcode mask, bit `cmd_src` of the source mask and bit `cmd_dst` of the destination mask are all 1, and the address test passes.
- R4: The address test passes when `((cmd_addr ^ cmp) & mask) == 0`. An address mask bit of 0 makes that address bit a don't-care.
- R5: With `trig_en` = 0 and `trace_en` = 1, a valid command is recorded exactly when it hits the filter. `rec_strobe` is high in the clock cycle after the command is presented.
- R6: With triggers on and the window closed, a filter hit that is not a start hit is not recorded.
- R7: A start hit opens the window, and the start command itself is recorded. `window_active` reads 1 from the following cycle onward.
- R8: While the window is open, a command is recorded when it hits the filter, the start trigger or the stop trigger, and is not recorded otherwise.
- R9: A stop hit inside the window is recorded, and `window_active` reads 0 in the following cycle. Later filter hits are not recorded.
- R10: A command that hits both the start and the stop trigger while the window is closed is recorded, and the window stays closed.
- R11: While `trace_en` = 0, nothing is recorded and the window is cleared. When tracing is enabled again, the window starts closed.
- R12: A cycle with `cmd_valid` = 0 records nothing and leaves the window state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trace_en | input | 1 | Tracing enable; a low level clears the window |
| trig_en | input | 1 | Selects window mode (1) or filter-only mode (0) |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 6 | Command opcode |
| cmd_src | input | 5 | Command source ID |
| cmd_dst | input | 5 | Command destination ID |
| cmd_addr | input | 40 | Command address |
| flt_op_mask | input | 64 | Filter opcode enable mask |
| flt_src_mask | input | 32 | Filter source mask |
| flt_dst_mask | input | 32 | Filter destination mask |
| flt_addr_cmp | input | 40 | Filter address compare value |
| flt_addr_mask | input | 40 | Filter address mask |
| sta_op_mask | input | 64 | Start trigger opcode enable mask |
| sta_src_mask | input | 32 | Start trigger source mask |
| sta_dst_mask | input | 32 | Start trigger destination mask |
| sta_addr_cmp | input | 40 | Start trigger address compare value |
| sta_addr_mask | input | 40 | Start trigger address mask |
| stp_op_mask | input | 64 | Stop trigger opcode enable mask |
| stp_src_mask | input | 32 | Stop trigger source mask |
| stp_dst_mask | input | 32 | Stop trigger destination mask |
| stp_addr_cmp | input | 40 | Stop trigger address compare value |
| stp_addr_mask | input | 40 | Stop trigger address mask |
| rec_strobe | output | 1 | One-cycle pulse: the previous cycle's command is recorded |
| window_active | output | 1 | Trigger window is open |

## Verification
The assertions check, on every cycle, the rules that need no knowledge of the masks:

- Excluded opcodes, cycles without a valid command and disabled tracing never produce a strobe.
- The window is never open while triggers are off.
- Every opening and every trigger-driven closing of the window coincides with a recorded command.

Whether a given mask setting hits or misses depends on the four field comparisons and on the window history. The bench's scenarios show this. They cover single-field misses, address don't-care bits, commands outside the window, a simultaneous start and stop, and re-enabling.

// File: rtl/trq_pkg.sv
package trq_pkg;

    // Window control states
    typedef enum logic [1:0] {
        TQ_OFF   = 2'd0,
        TQ_FREE  = 2'd1,
        TQ_ARMED = 2'd2,
        TQ_OPEN  = 2'd3
    } trq_state_e;

    // Indices of the three match units
    localparam int UNIT_FLT = 0;
    localparam int UNIT_STA = 1;
    localparam int UNIT_STP = 2;
    localparam int NUM_UNITS = 3;

endpackage

// File: rtl/trq_match.sv
module trq_match #(
    parameter int OP_W   = 6,
    parameter int ID_W   = 5,
    parameter int ADDR_W = 40,
    localparam int OP_N  = 1 << OP_W,
    localparam int ID_N  = 1 << ID_W
) (
    input  logic [OP_W-1:0]   op,
    input  logic [ID_W-1:0]   src,
    input  logic [ID_W-1:0]   dst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [OP_N-1:0]   op_mask,
    input  logic [ID_N-1:0]   src_mask,
    input  logic [ID_N-1:0]   dst_mask,
    input  logic [ADDR_W-1:0] addr_cmp,
    input  logic [ADDR_W-1:0] addr_mask,
    output logic              hit
);

    logic op_ok;
    logic src_ok;
    logic dst_ok;
    logic addr_ok;

    always_comb begin
        op_ok   = op_mask[op];
        src_ok  = src_mask[src];
        dst_ok  = dst_mask[dst];
        addr_ok = ((addr ^ addr_cmp) & addr_mask) == '0;
        hit     = op_ok & src_ok & dst_ok & addr_ok;
    end

endmodule

// File: rtl/trq_window_fsm.sv
module trq_window_fsm
    import trq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trace_en,
    input  logic trig_en,
    input  logic cmd_ok,
    input  logic hit_flt,
    input  logic hit_sta,
    input  logic hit_stp,
    output logic rec_strobe,
    output logic window_active
);

    trq_state_e state_q;
    trq_state_e state_d;
    logic       open_evt;
    logic       close_evt;
    logic       in_window;
    logic       rec_d;

    always_comb begin
        open_evt  = cmd_ok & hit_sta & ~hit_stp;
        close_evt = cmd_ok & hit_stp;
        in_window = (state_q == TQ_OPEN) | (cmd_ok & hit_sta);
        if (trig_en)
            rec_d = trace_en & cmd_ok & in_window & (hit_flt | hit_sta | hit_stp);
        else
            rec_d = trace_en & cmd_ok & hit_flt;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TQ_OFF: begin
                if (trace_en) begin
                    if (!trig_en)      state_d = TQ_FREE;
                    else if (open_evt) state_d = TQ_OPEN;
                    else               state_d = TQ_ARMED;
                end
            end
            TQ_FREE: begin
                if (!trace_en)    state_d = TQ_OFF;
                else if (trig_en) state_d = TQ_ARMED;
            end
            TQ_ARMED: begin
                if (!trace_en)     state_d = TQ_OFF;
                else if (!trig_en) state_d = TQ_FREE;
                else if (open_evt) state_d = TQ_OPEN;
            end
            TQ_OPEN: begin
                if (!trace_en)      state_d = TQ_OFF;
                else if (!trig_en)  state_d = TQ_FREE;
                else if (close_evt) state_d = TQ_ARMED;
            end
            default: state_d = TQ_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TQ_OFF;
        else        state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rec_strobe    <= 1'b0;
            window_active <= 1'b0;
        end else begin
            rec_strobe    <= rec_d;
            window_active <= (state_d == TQ_OPEN);
        end
    end

endmodule

// File: rtl/trace_qual_top.sv
module trace_qual_top
    import trq_pkg::*;
#(
    parameter int OP_W     = 6,
    parameter int ID_W     = 5,
    parameter int ADDR_W   = 40,
    parameter int IDLE_OP  = 0,
    parameter int IORSP_OP = 7,
    localparam int OP_N    = 1 << OP_W,
    localparam int ID_N    = 1 << ID_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trace_en,
    input  logic              trig_en,
    input  logic              cmd_valid,
    input  logic [OP_W-1:0]   cmd_op,
    input  logic [ID_W-1:0]   cmd_src,
    input  logic [ID_W-1:0]   cmd_dst,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [OP_N-1:0]   flt_op_mask,
    input  logic [ID_N-1:0]   flt_src_mask,
    input  logic [ID_N-1:0]   flt_dst_mask,
    input  logic [ADDR_W-1:0] flt_addr_cmp,
    input  logic [ADDR_W-1:0] flt_addr_mask,
    input  logic [OP_N-1:0]   sta_op_mask,
    input  logic [ID_N-1:0]   sta_src_mask,
    input  logic [ID_N-1:0]   sta_dst_mask,
    input  logic [ADDR_W-1:0] sta_addr_cmp,
    input  logic [ADDR_W-1:0] sta_addr_mask,
    input  logic [OP_N-1:0]   stp_op_mask,
    input  logic [ID_N-1:0]   stp_src_mask,
    input  logic [ID_N-1:0]   stp_dst_mask,
    input  logic [ADDR_W-1:0] stp_addr_cmp,
    input  logic [ADDR_W-1:0] stp_addr_mask,
    output logic              rec_strobe,
    output logic              window_active
);

    localparam logic [OP_W-1:0] IDLE_CODE  = OP_W'(IDLE_OP);
    localparam logic [OP_W-1:0] IORSP_CODE = OP_W'(IORSP_OP);

    logic [NUM_UNITS-1:0][OP_N-1:0]   u_op_mask;
    logic [NUM_UNITS-1:0][ID_N-1:0]   u_src_mask;
    logic [NUM_UNITS-1:0][ID_N-1:0]   u_dst_mask;
    logic [NUM_UNITS-1:0][ADDR_W-1:0] u_addr_cmp;
    logic [NUM_UNITS-1:0][ADDR_W-1:0] u_addr_mask;
    logic [NUM_UNITS-1:0]             u_hit;
    logic                             excluded;
    logic                             cmd_ok;

    always_comb begin
        u_op_mask[UNIT_FLT]   = flt_op_mask;
        u_src_mask[UNIT_FLT]  = flt_src_mask;
        u_dst_mask[UNIT_FLT]  = flt_dst_mask;
        u_addr_cmp[UNIT_FLT]  = flt_addr_cmp;
        u_addr_mask[UNIT_FLT] = flt_addr_mask;
        u_op_mask[UNIT_STA]   = sta_op_mask;
        u_src_mask[UNIT_STA]  = sta_src_mask;
        u_dst_mask[UNIT_STA]  = sta_dst_mask;
        u_addr_cmp[UNIT_STA]  = sta_addr_cmp;
        u_addr_mask[UNIT_STA] = sta_addr_mask;
        u_op_mask[UNIT_STP]   = stp_op_mask;
        u_src_mask[UNIT_STP]  = stp_src_mask;
        u_dst_mask[UNIT_STP]  = stp_dst_mask;
        u_addr_cmp[UNIT_STP]  = stp_addr_cmp;
        u_addr_mask[UNIT_STP] = stp_addr_mask;
    end

    // Opcodes that can never be traced
    always_comb begin
        excluded = (cmd_op == IDLE_CODE) | (cmd_op == IORSP_CODE);
        cmd_ok   = cmd_valid & ~excluded;
    end

    for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
        trq_match #(
            .OP_W  (OP_W),
            .ID_W  (ID_W),
            .ADDR_W(ADDR_W)
        ) u_match (
            .op       (cmd_op),
            .src      (cmd_src),
            .dst      (cmd_dst),
            .addr     (cmd_addr),
            .op_mask  (u_op_mask[g]),
            .src_mask (u_src_mask[g]),
            .dst_mask (u_dst_mask[g]),
            .addr_cmp (u_addr_cmp[g]),
            .addr_mask(u_addr_mask[g]),
            .hit      (u_hit[g])
        );
    end

    trq_window_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .trace_en     (trace_en),
        .trig_en      (trig_en),
        .cmd_ok       (cmd_ok),
        .hit_flt      (u_hit[UNIT_FLT]),
        .hit_sta      (u_hit[UNIT_STA]),
        .hit_stp      (u_hit[UNIT_STP]),
        .rec_strobe   (rec_strobe),
        .window_active(window_active)
    );

endmodule

// File: rtl/trq_checker.sv
module trq_checker #(
    parameter int OP_W     = 6,
    parameter int IDLE_OP  = 0,
    parameter int IORSP_OP = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic            trace_en,
    input logic            trig_en,
    input logic            cmd_valid,
    input logic [OP_W-1:0] cmd_op,
    input logic            rec_strobe,
    input logic            window_active
);

    logic op_barred;
    assign op_barred = (cmd_op == OP_W'(IDLE_OP)) || (cmd_op == OP_W'(IORSP_OP));

    AST_BARRED_OP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && op_barred |=> !rec_strobe) else $error("barred opcode recorded"); // R2

    AST_NOVALID_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !rec_strobe) else $error("strobe without command"); // R12

    AST_DISABLED_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !trace_en |=> !rec_strobe && !window_active) else $error("activity while disabled"); // R11

    AST_NO_WINDOW_FILTER_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        trace_en && !trig_en |=> !window_active) else $error("window open in filter mode"); // R5

    AST_OPEN_RECORDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(window_active) |-> rec_strobe) else $error("window opened without record"); // R7

    AST_CLOSE_RECORDS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(window_active) && $past(trace_en) && $past(trig_en) |-> rec_strobe)
        else $error("window closed without record"); // R9

endmodule

bind trace_qual_top trq_checker #(
    .OP_W    (OP_W),
    .IDLE_OP (IDLE_OP),
    .IORSP_OP(IORSP_OP)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .trace_en     (trace_en),
    .trig_en      (trig_en),
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .rec_strobe   (rec_strobe),
    .window_active(window_active)
);

// File: tb/trace_qual_top_test.sv
module trace_qual_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trace_en = 1'b0;
    logic        trig_en = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [5:0]  cmd_op = '0;
    logic [4:0]  cmd_src = '0;
    logic [4:0]  cmd_dst = '0;
    logic [39:0] cmd_addr = '0;
    logic [63:0] flt_op_mask, sta_op_mask, stp_op_mask;
    logic [31:0] flt_src_mask, sta_src_mask, stp_src_mask;
    logic [31:0] flt_dst_mask, sta_dst_mask, stp_dst_mask;
    logic [39:0] flt_addr_cmp, sta_addr_cmp, stp_addr_cmp;
    logic [39:0] flt_addr_mask, sta_addr_mask, stp_addr_mask;
    logic        rec_strobe;
    logic        window_active;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    trace_qual_top uut (
        .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .trig_en(trig_en),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_src(cmd_src),
        .cmd_dst(cmd_dst), .cmd_addr(cmd_addr),
        .flt_op_mask(flt_op_mask), .flt_src_mask(flt_src_mask),
        .flt_dst_mask(flt_dst_mask), .flt_addr_cmp(flt_addr_cmp),
        .flt_addr_mask(flt_addr_mask),
        .sta_op_mask(sta_op_mask), .sta_src_mask(sta_src_mask),
        .sta_dst_mask(sta_dst_mask), .sta_addr_cmp(sta_addr_cmp),
        .sta_addr_mask(sta_addr_mask),
        .stp_op_mask(stp_op_mask), .stp_src_mask(stp_src_mask),
        .stp_dst_mask(stp_dst_mask), .stp_addr_cmp(stp_addr_cmp),
        .stp_addr_mask(stp_addr_mask),
        .rec_strobe(rec_strobe), .window_active(window_active)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic defaults();
        flt_op_mask = 64'h1 << 5;  flt_src_mask = '1; flt_dst_mask = '1;
        flt_addr_cmp = '0; flt_addr_mask = '0;
        sta_op_mask = 64'h1 << 10; sta_src_mask = '1; sta_dst_mask = '1;
        sta_addr_cmp = '0; sta_addr_mask = '0;
        stp_op_mask = 64'h1 << 11; stp_src_mask = '1; stp_dst_mask = '1;
        stp_addr_cmp = '0; stp_addr_mask = '0;
    endtask

    // Present one command at a falling edge, sample results one cycle later
    task automatic send(input logic [5:0] op, input logic [4:0] s,
                        input logic [4:0] d, input logic [39:0] a,
                        input string req, input logic exp_rec, input logic exp_win);
        cmd_valid = 1'b1; cmd_op = op; cmd_src = s; cmd_dst = d; cmd_addr = a;
        @(negedge clk);
        cmd_valid = 1'b0;
        check({req, " rec"}, rec_strobe, exp_rec);
        check({req, " win"}, window_active, exp_win);
    endtask

    task automatic restart(input logic trig);
        trace_en = 1'b0; @(negedge clk);
        trig_en = trig; trace_en = 1'b1; @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 rec", rec_strobe, 1'b0);
        check("R1 win", window_active, 1'b0);
    endtask

    task automatic t_filter_only();
        restart(1'b0);
        send(6'd5, 5'd1, 5'd1, 40'h0, "R5 hit", 1'b1, 1'b0);
        send(6'd6, 5'd1, 5'd1, 40'h0, "R5 miss", 1'b0, 1'b0);
        flt_op_mask = '1;
        send(6'd0, 5'd1, 5'd1, 40'h0, "R2 idle", 1'b0, 1'b0);
        send(6'd7, 5'd1, 5'd1, 40'h0, "R2 iorsp", 1'b0, 1'b0);
        send(6'd1, 5'd1, 5'd1, 40'h0, "R5 allmask", 1'b1, 1'b0);
        defaults();
    endtask

    task automatic t_fields();
        restart(1'b0);
        flt_src_mask = 32'h1 << 3;
        send(6'd5, 5'd3, 5'd2, 40'h0, "R3 src hit", 1'b1, 1'b0);
        send(6'd5, 5'd4, 5'd2, 40'h0, "R3 src miss", 1'b0, 1'b0);
        flt_src_mask = '1; flt_dst_mask = 32'h1 << 9;
        send(6'd5, 5'd4, 5'd9, 40'h0, "R3 dst hit", 1'b1, 1'b0);
        send(6'd5, 5'd4, 5'd2, 40'h0, "R3 dst miss", 1'b0, 1'b0);
        send(6'd4, 5'd4, 5'd9, 40'h0, "R3 op miss", 1'b0, 1'b0);
        defaults();
    endtask

    task automatic t_addr();
        restart(1'b0);
        flt_addr_cmp = 40'h00_1234_0000; flt_addr_mask = 40'h00_FFFF_0000;
        send(6'd5, 5'd0, 5'd0, 40'hAB_1234_ABCD, "R4 dontcare", 1'b1, 1'b0);
        send(6'd5, 5'd0, 5'd0, 40'h00_1235_0000, "R4 mismatch", 1'b0, 1'b0);
        defaults();
    endtask

    task automatic t_window();
        restart(1'b1);
        send(6'd5, 5'd0, 5'd0, 40'h0, "R6 closed", 1'b0, 1'b0);
        send(6'd10, 5'd0, 5'd0, 40'h0, "R7 start", 1'b1, 1'b1);
        send(6'd5, 5'd0, 5'd0, 40'h0, "R8 filter", 1'b1, 1'b1);
        send(6'd6, 5'd0, 5'd0, 40'h0, "R8 none", 1'b0, 1'b1);
        send(6'd10, 5'd0, 5'd0, 40'h0, "R8 start again", 1'b1, 1'b1);
        @(negedge clk);
        check("R12 idle rec", rec_strobe, 1'b0);
        check("R12 idle win", window_active, 1'b1);
        send(6'd11, 5'd0, 5'd0, 40'h0, "R9 stop", 1'b1, 1'b0);
        send(6'd5, 5'd0, 5'd0, 40'h0, "R9 after", 1'b0, 1'b0);
        sta_op_mask = '1;
        send(6'd0, 5'd0, 5'd0, 40'h0, "R2 no trigger", 1'b0, 1'b0);
        defaults();
    endtask

    task automatic t_both();
        restart(1'b1);
        sta_op_mask = sta_op_mask | (64'h1 << 12);
        stp_op_mask = stp_op_mask | (64'h1 << 12);
        send(6'd12, 5'd0, 5'd0, 40'h0, "R10 both", 1'b1, 1'b0);
        send(6'd5, 5'd0, 5'd0, 40'h0, "R10 still closed", 1'b0, 1'b0);
        defaults();
    endtask

    task automatic t_reenable();
        restart(1'b1);
        send(6'd10, 5'd0, 5'd0, 40'h0, "R11 open", 1'b1, 1'b1);
        trace_en = 1'b0;
        send(6'd5, 5'd0, 5'd0, 40'h0, "R11 disabled", 1'b0, 1'b0);
        trace_en = 1'b1;
        send(6'd5, 5'd0, 5'd0, 40'h0, "R11 reenabled", 1'b0, 1'b0);
    endtask

    initial begin
        defaults();
        repeat (2) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_filter_only();
        t_fields();
        t_addr();
        t_window();
        t_both();
        t_reenable();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule